// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Idle-Line Wakeup and Break Transmit

This block receives asynchronous serial characters from a single input line. It oversamples the line with a tick that runs at sixteen times the bit rate. A majority vote over three samples taken at the middle of each bit gives the value of that bit. Characters are 8 or 9 data bits long, sent least significant bit first, with one start bit and one stop bit. A finished character goes into a data register. A status register reports receive-full, idle-line, overrun, noise and framing conditions. Software clears these flags with a two-step sequence: a status read, then a data read.

A wakeup control bit puts the receiver to sleep. While it is set, completed characters are dropped, no flag is raised and the interrupt output stays low. When the line has been idle for a full character time, hardware clears the wakeup bit and reception resumes.

The idle-line flag fires only once per quiet period. After it has fired, it is re-armed only when the line goes low again.

The same register port holds a send-break bit. While that bit is set, the transmit line is held low.

Top module: `sciRxWakeTop`

## Requirements
- R1: After reset, status, data and both control registers read as zero, the interrupt output is low and the transmit line is high.
- R2: A low start bit, 8 data bits (least significant first) and a high stop bit load the data register and set receive-full (status bit 5). Both happen on the ninth oversample tick of the stop bit.
- R3: With nine-bit mode set (control 1 bit 4), 9 data bits are received. The ninth data bit appears in control 1 bit 7, and the low eight bits appear in the data register.
- R4: Each bit value is the majority of the samples on oversample ticks 7, 8 and 9 of that bit. Any disagreement among the three samples of any bit in a frame sets noise (status bit 2) when that character loads.
- R5: A stop bit that votes low sets framing (status bit 1). The character is still loaded.
- R6: A character that completes while receive-full is still set raises overrun (status bit 3) and leaves the data register unchanged.
- R7: A data read clears exactly those flags that were set at the most recent status read. A data read with no prior status read clears nothing. A flag that sets after the status read survives the data read.
- R8: Idle-line (status bit 4) sets on the 160th consecutive high tick (8-bit mode) or the 176th (9-bit mode), counted since the last low tick.
- R9: Idle-line sets only if the line has been low since reset or since the previous idle detection.
- R10: While wakeup (control 2 bit 1) is set, completed characters change no flag or data, and idle detection sets no flag. Idle detection instead clears the wakeup bit.
- R11: The interrupt output equals (receive enable, control 2 bit 5, AND (receive-full OR overrun)) OR (idle enable, control 2 bit 4, AND idle-line), and it is held low while wakeup is set.
- R12: The transmit line goes low on the clock after send-break (control 2 bit 0) is written to 1. It stays low while the bit is held and goes high on the clock after the bit is cleared.
- R13: A start bit whose vote is high is discarded without any flag change, and the receiver goes back to hunting for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxLine | input | 1 | Serial receive line |
| wrEn | input | 1 | Control register write strobe |
| wrSel | input | 1 | Write target: 0 control 1, 1 control 2 |
| wrData | input | 8 | Write data |
| statusRd | input | 1 | Status register read strobe |
| dataRd | input | 1 | Data register read strobe |
| statusQ | output | 8 | Status: bit 5 full, 4 idle, 3 overrun, 2 noise, 1 framing |
| dataQ | output | 8 | Received character |
| ctrl1Q | output | 8 | Control 1: bit 7 ninth received bit, bit 4 nine-bit mode |
| ctrl2Q | output | 8 | Control 2: bit 5 receive int enable, bit 4 idle int enable, bit 1 wakeup, bit 0 send-break |
| irq | output | 1 | Interrupt request |
| txLine | output | 1 | Transmit line, low during break |

## Verification
The assertions make several assumptions about the inputs:
- The baud tick is a single-cycle pulse, spaced far enough apart that the two-stage line synchronizer settles between ticks.
- The status and data read strobes never land on the same cycle.
- A control write never lands on the same edge as an idle detection.

The stimulus stays within these limits. It raises the tick on every fourth clock and changes the receive line only one step after a tick. It issues each read and write strobe alone on a one-cycle pulse placed between falling edges. Glitches are limited to a single oversample tick, and a bad stop bit returns high after its mid-bit samples.

// File: rtl/sciRxPkg.sv
package sciRxPkg;
  // strobes from the bit-timing control to the receive datapath
  typedef struct packed {
    logic startSeen;   // falling edge seen while hunting
    logic sampleEn;    // capture an early mid-bit sample
    logic bitDone;     // third mid-bit sample: vote is valid
    logic shiftEn;     // push voted data bit
    logic frameEnd;    // stop bit voted, character complete
    logic abortStart;  // start bit voted high
  } rxStrobeT;
endpackage

// File: rtl/sciRxCtrl.sv
module sciRxCtrl
  import sciRxPkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     baudTick,
  input  logic     rxS,
  input  logic     vote,
  input  logic     nineBit,
  output rxStrobeT stb
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int MID   = OVERSAMPLE / 2;
  localparam int IDX_W = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {HUNT, START, DATA, STOP} rxStateT;

  rxStateT            state;
  logic [CNT_W-1:0]   cnt;
  logic [IDX_W-1:0]   bitIdx;
  logic [IDX_W-1:0]   lastIdx;
  logic               lastCnt;
  logic               busy;

  assign lastCnt = (cnt == CNT_W'(OVERSAMPLE - 1));
  assign lastIdx = nineBit ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
  assign busy    = (state != HUNT);

  always_comb begin
    stb            = '0;
    stb.startSeen  = baudTick && !busy && !rxS;
    stb.sampleEn   = baudTick && busy &&
                     ((cnt == CNT_W'(MID - 1)) || (cnt == CNT_W'(MID)));
    stb.bitDone    = baudTick && busy && (cnt == CNT_W'(MID + 1));
    stb.shiftEn    = stb.bitDone && (state == DATA);
    stb.frameEnd   = stb.bitDone && (state == STOP);
    stb.abortStart = stb.bitDone && (state == START) && vote;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= HUNT;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (baudTick) begin
      if (busy) cnt <= lastCnt ? '0 : cnt + 1'b1;
      case (state)
        HUNT: begin
          if (!rxS) begin
            state <= START;
            cnt   <= CNT_W'(1);
          end
        end
        START: begin
          if (stb.abortStart) state <= HUNT;
          else if (lastCnt) begin
            state  <= DATA;
            bitIdx <= '0;
          end
        end
        DATA: begin
          if (lastCnt) begin
            if (bitIdx == lastIdx) state <= STOP;
            else bitIdx <= bitIdx + 1'b1;
          end
        end
        STOP: begin
          if (stb.frameEnd) state <= HUNT;
        end
        default: state <= HUNT;
      endcase
    end
  end

  // R13: at most one frame-level strobe per cycle
  a_r13_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.startSeen, stb.shiftEn, stb.frameEnd, stb.abortStart}));

  // R13: an aborted start leaves the receiver hunting on the next cycle
  a_r13_abort_to_hunt: assert property (@(posedge clk) disable iff (!rstN)
    stb.abortStart |=> !busy);
endmodule

// File: rtl/sciRxDatapath.sv
module sciRxDatapath
  import sciRxPkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              rxLine,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [7:0]        wrData,
  input  logic              statusRd,
  input  logic              dataRd,
  input  rxStrobeT          stb,
  output logic              rxS,
  output logic              vote,
  output logic              nineBit,
  output logic [7:0]        statusQ,
  output logic [DATA_W-1:0] dataQ,
  output logic [7:0]        ctrl1Q,
  output logic [7:0]        ctrl2Q,
  output logic              irq,
  output logic              txLine
);
  localparam int IDLE8  = OVERSAMPLE * (DATA_W + 2);
  localparam int IDLE9  = OVERSAMPLE * (DATA_W + 3);
  localparam int IDLE_W = $clog2(IDLE9 + 1);
  localparam int FLAG_N = 5;
  // flag vector order: full, idle, overrun, noise, framing
  localparam int F_FULL = 4;
  localparam int F_IDLE = 3;
  localparam int F_OVR  = 2;
  localparam int F_NSE  = 1;
  localparam int F_FRM  = 0;

  logic              rxMeta;
  logic              sampA, sampB;
  logic              noisy, frameNoise;
  logic [DATA_W:0]   shReg;
  logic              rxBit8;
  logic              rxIntEn, idleIntEn, wakeUp, sendBreak;
  logic [FLAG_N-1:0] flags, armMask, clrMask, setMask;
  logic [IDLE_W-1:0] idleCnt, idleThr;
  logic              idleArmed, idleEvent;
  logic              loadChar;
  logic [7:0]        wrDataUnused;

  assign wrDataUnused = {wrData[7:6], wrData[3:2], 4'b0};

  // two-stage line synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxS    <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxS    <= rxMeta;
    end
  end

  // three-point mid-bit vote
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampA <= 1'b1;
      sampB <= 1'b1;
    end else if (stb.sampleEn) begin
      sampA <= sampB;
      sampB <= rxS;
    end
  end

  assign vote  = (sampA & sampB) | (sampA & rxS) | (sampB & rxS);
  assign noisy = !((sampA == sampB) && (sampB == rxS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameNoise <= 1'b0;
      shReg      <= '0;
    end else if (stb.startSeen) begin
      frameNoise <= 1'b0;
      shReg      <= '0;
    end else begin
      if (stb.bitDone && noisy) frameNoise <= 1'b1;
      if (stb.shiftEn) shReg <= {vote, shReg[DATA_W:1]};
    end
  end

  // idle-line detector on the raw synchronized line
  assign idleThr   = nineBit ? IDLE_W'(IDLE9 - 1) : IDLE_W'(IDLE8 - 1);
  assign idleEvent = baudTick && rxS && idleArmed && (idleCnt == idleThr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt   <= '0;
      idleArmed <= 1'b0;
    end else if (baudTick) begin
      if (!rxS) begin
        idleCnt   <= '0;
        idleArmed <= 1'b1;
      end else begin
        if (idleCnt != IDLE_W'(IDLE9)) idleCnt <= idleCnt + 1'b1;
        if (idleEvent) idleArmed <= 1'b0;
      end
    end
  end

  // control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nineBit   <= 1'b0;
      rxIntEn   <= 1'b0;
      idleIntEn <= 1'b0;
      wakeUp    <= 1'b0;
      sendBreak <= 1'b0;
    end else begin
      if (idleEvent && wakeUp) wakeUp <= 1'b0;
      if (wrEn) begin
        if (!wrSel) nineBit <= wrData[4];
        else begin
          rxIntEn   <= wrData[5];
          idleIntEn <= wrData[4];
          wakeUp    <= wrData[1];
          sendBreak <= wrData[0];
        end
      end
    end
  end

  // flag set / two-step clear
  assign loadChar = stb.frameEnd && !wakeUp && !flags[F_FULL];
  assign clrMask  = dataRd ? armMask : '0;

  always_comb begin
    setMask         = '0;
    setMask[F_FULL] = loadChar;
    setMask[F_OVR]  = stb.frameEnd && !wakeUp && flags[F_FULL];
    setMask[F_NSE]  = loadChar && (frameNoise || noisy);
    setMask[F_FRM]  = loadChar && !vote;
    setMask[F_IDLE] = idleEvent && !wakeUp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags   <= '0;
      armMask <= '0;
      dataQ   <= '0;
      rxBit8  <= 1'b0;
    end else begin
      flags <= (flags & ~clrMask) | setMask;
      if (dataRd)   armMask <= '0;
      if (statusRd) armMask <= flags;
      if (loadChar) begin
        dataQ  <= nineBit ? shReg[DATA_W-1:0] : shReg[DATA_W:1];
        rxBit8 <= nineBit & shReg[DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) txLine <= 1'b1;
    else       txLine <= !sendBreak;
  end

  assign statusQ = {2'b00, flags, 1'b0};
  assign ctrl1Q  = {rxBit8, 2'b00, nineBit, 4'b0000};
  assign ctrl2Q  = {2'b00, rxIntEn, idleIntEn, 2'b00, wakeUp, sendBreak};
  assign irq     = !wakeUp && ((rxIntEn && (flags[F_FULL] || flags[F_OVR])) ||
                               (idleIntEn && flags[F_IDLE]));

  // R2: a completed frame with an empty holding register raises full
  a_r2_full_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameEnd && !wakeUp && !flags[F_FULL]) |=> flags[F_FULL]);

  // R6: a frame arriving into a full register keeps the old data
  a_r6_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameEnd && !wakeUp && flags[F_FULL]) |=> (flags[F_OVR] && $stable(dataQ)));

  // R7: a flag only drops on a data read
  a_r7_clear_needs_data_read: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flags[F_FULL]) |-> $past(dataRd));

  // R9: idle flag only rises when the line has been active
  a_r9_idle_needs_activity: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[F_IDLE]) |-> $past(idleArmed));

  // R10: frames completing in wakeup leave data and flags alone
  a_r10_wake_drops_frame: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameEnd && wakeUp && !dataRd) |=> ($stable(dataQ) && $stable(flags[F_FULL])));

  // R12: break drives the line low
  a_r12_break_low: assert property (@(posedge clk) disable iff (!rstN)
    sendBreak |=> !txLine);
endmodule

// File: rtl/sciRxWakeTop.sv
module sciRxWakeTop
  import sciRxPkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              rxLine,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [7:0]        wrData,
  input  logic              statusRd,
  input  logic              dataRd,
  output logic [7:0]        statusQ,
  output logic [DATA_W-1:0] dataQ,
  output logic [7:0]        ctrl1Q,
  output logic [7:0]        ctrl2Q,
  output logic              irq,
  output logic              txLine
);
  rxStrobeT stb;
  logic     rxS, vote, nineBit;

  sciRxCtrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxS(rxS), .vote(vote),
    .nineBit(nineBit), .stb(stb)
  );

  sciRxDatapath #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxLine(rxLine),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .statusRd(statusRd),
    .dataRd(dataRd), .stb(stb), .rxS(rxS), .vote(vote), .nineBit(nineBit),
    .statusQ(statusQ), .dataQ(dataQ), .ctrl1Q(ctrl1Q), .ctrl2Q(ctrl2Q),
    .irq(irq), .txLine(txLine)
  );
endmodule

// File: tb/sciRxWakeTop_bench.sv
`timescale 1ns/1ps
module sciRxWakeTop_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b0;
  logic rxDrv = 1'b1;
  logic wrEn = 1'b0, wrSel = 1'b0, statusRd = 1'b0, dataRd = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] statusQ, dataQ, ctrl1Q, ctrl2Q;
  logic irq, txLine;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sciRxWakeTop u_sciRxWakeTop (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxLine(rxDrv),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .statusRd(statusRd),
    .dataRd(dataRd), .statusQ(statusQ), .dataQ(dataQ), .ctrl1Q(ctrl1Q),
    .ctrl2Q(ctrl2Q), .irq(irq), .txLine(txLine)
  );

  // baud tick every fourth clock
  int tickDiv = 0;
  always @(posedge clk) begin
    tickDiv  <= (tickDiv + 1) % 4;
    baudTick <= (tickDiv == 3);
  end

  // ---------------- behavioural reference model ----------------
  logic [7:0] mStatus, mData;
  logic mBit8, mNine, mRie, mIlie, mRwu, mSbk, mTx;
  logic [7:0] mArm;
  int   mOnes;
  bit   mArmed, mBusy, mNoisy, mS7, mS8;
  int   mIdx;
  logic mBits[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mStatus = 0; mData = 0; mBit8 = 0; mNine = 0; mRie = 0; mIlie = 0;
      mRwu = 0; mSbk = 0; mTx = 1; mArm = 0; mOnes = 0; mArmed = 0;
      mBusy = 0; mNoisy = 0; mIdx = 0; mBits.delete();
    end else begin
      logic [7:0] setM, clrM;
      bit rwuClr;
      setM = 0; rwuClr = 0;
      mTx = !mSbk;
      clrM = dataRd ? mArm : 8'h00;
      if (dataRd) mArm = 0;
      if (statusRd) mArm = mStatus;
      if (baudTick) begin
        if (!rxDrv) begin mOnes = 0; mArmed = 1; end
        else begin
          mOnes++;
          if (mArmed && mOnes == (mNine ? 176 : 160)) begin
            mArmed = 0;
            if (mRwu) rwuClr = 1; else setM[4] = 1;
          end
        end
        if (!mBusy) begin
          if (!rxDrv) begin mBusy = 1; mIdx = 0; mNoisy = 0; mBits.delete(); end
        end else begin
          int pos, bitNo, nb;
          bit v;
          mIdx++;
          pos = mIdx % 16; bitNo = mIdx / 16; nb = mNine ? 9 : 8;
          if (pos == 7) mS7 = rxDrv;
          if (pos == 8) mS8 = rxDrv;
          if (pos == 9) begin
            v = (int'(mS7) + int'(mS8) + int'(rxDrv)) >= 2;
            if (!(mS7 == mS8 && mS8 == rxDrv)) mNoisy = 1;
            if (bitNo == 0) begin
              if (v) mBusy = 0;
            end else if (bitNo <= nb) mBits.push_back(v);
            else begin
              mBusy = 0;
              if (!mRwu) begin
                if (mStatus[5]) setM[3] = 1;
                else begin
                  for (int i = 0; i < 8; i++) mData[i] = mBits[i];
                  mBit8 = mNine ? mBits[8] : 1'b0;
                  setM[5] = 1;
                  if (mNoisy) setM[2] = 1;
                  if (!v) setM[1] = 1;
                end
              end
            end
          end
        end
      end
      mStatus = (mStatus & ~clrM) | setM;
      if (rwuClr) mRwu = 0;
      if (wrEn) begin
        if (!wrSel) mNine = wrData[4];
        else begin mRie = wrData[5]; mIlie = wrData[4]; mRwu = wrData[1]; mSbk = wrData[0]; end
      end
    end
  end

  task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // compare on every clock
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic expIrq;
      expIrq = !mRwu && ((mRie && (mStatus[5] || mStatus[3])) || (mIlie && mStatus[4]));
      cmp("R2 full", {7'b0, statusQ[5]}, {7'b0, mStatus[5]});
      cmp("R8 idle", {7'b0, statusQ[4]}, {7'b0, mStatus[4]});
      cmp("R6 overrun", {7'b0, statusQ[3]}, {7'b0, mStatus[3]});
      cmp("R4 noise", {7'b0, statusQ[2]}, {7'b0, mStatus[2]});
      cmp("R5 framing", {7'b0, statusQ[1]}, {7'b0, mStatus[1]});
      cmp("R2 data", dataQ, mData);
      cmp("R3 ctrl1", ctrl1Q, {mBit8, 2'b0, mNine, 4'b0});
      cmp("R10 ctrl2", ctrl2Q, {2'b0, mRie, mIlie, 2'b0, mRwu, mSbk});
      cmp("R11 irq", {7'b0, irq}, {7'b0, expIrq});
      cmp("R12 tx", {7'b0, txLine}, {7'b0, mTx});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic waitTick();
    @(posedge clk);
    while (!baudTick) @(posedge clk);
    #1;
  endtask

  task automatic holdTicks(int n);
    for (int i = 0; i < n; i++) waitTick();
  endtask

  task automatic sendFrame(logic [8:0] val, bit nine, int glitchBit, bit badStop);
    int nb;
    nb = nine ? 9 : 8;
    waitTick();
    for (int b = 0; b < nb + 2; b++) begin
      for (int p = 0; p < 16; p++) begin
        logic v;
        if (b == 0) v = 1'b0;
        else if (b <= nb) v = val[b-1];
        else v = badStop ? (p > 9) : 1'b1;
        if (b == glitchBit && p == 8) v = ~v;
        rxDrv = v;
        waitTick();
      end
    end
    rxDrv = 1'b1;
  endtask

  task automatic regWrite(bit sel, logic [7:0] d);
    @(negedge clk); wrEn = 1; wrSel = sel; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic readStatus();
    @(negedge clk); statusRd = 1;
    @(negedge clk); statusRd = 0;
  endtask

  task automatic readData();
    @(negedge clk); dataRd = 1;
    @(negedge clk); dataRd = 0;
  endtask

  task automatic clearAll();
    readStatus(); readData();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 status", statusQ, 8'h00);
    cmp("R1 data", dataQ, 8'h00);
    cmp("R1 ctrl", {ctrl1Q | ctrl2Q}, 8'h00);
    cmp("R1 irq/tx", {6'b0, irq, txLine}, 8'h01);

    // R9 no idle without activity
    holdTicks(200);
    cmp("R9 no idle from reset", {7'b0, statusQ[4]}, 8'h00);

    // R2 plain 8-bit character
    sendFrame(9'h0A5, 0, -1, 0);
    @(negedge clk);
    cmp("R2 data A5", dataQ, 8'hA5);
    cmp("R2 status", statusQ, 8'h20);

    // R8 idle after a character time
    holdTicks(165);
    cmp("R8 idle set", {7'b0, statusQ[4]}, 8'h01);
    clearAll();
    cmp("R7 cleared", statusQ, 8'h00);

    // R9 no re-arm without activity
    holdTicks(200);
    cmp("R9 idle stays clear", statusQ, 8'h00);

    // R6 overrun
    sendFrame(9'h03C, 0, -1, 0);
    sendFrame(9'h05A, 0, -1, 0);
    @(negedge clk);
    cmp("R6 data kept", dataQ, 8'h3C);
    cmp("R6 overrun", {7'b0, statusQ[3]}, 8'h01);

    // R7 data read alone clears nothing
    readData();
    cmp("R7 lone data read", {6'b0, statusQ[5], statusQ[3]}, 8'h03);
    // R7 flag set after status read survives
    readStatus();
    holdTicks(170);
    readData();
    cmp("R7 late idle survives", statusQ, 8'h10);
    clearAll();
    cmp("R7 all clear", statusQ, 8'h00);

    // R3 nine-bit mode
    regWrite(0, 8'h10);
    cmp("R3 mode bit", ctrl1Q, 8'h10);
    sendFrame(9'h1C3, 1, -1, 0);
    @(negedge clk);
    cmp("R3 low byte", dataQ, 8'hC3);
    cmp("R3 ninth bit", ctrl1Q, 8'h90);
    holdTicks(100);
    cmp("R8 no idle before 176", {7'b0, statusQ[4]}, 8'h00);
    holdTicks(20);
    cmp("R8 idle at 176", {7'b0, statusQ[4]}, 8'h01);
    clearAll();
    regWrite(0, 8'h00);

    // R4 noise
    sendFrame(9'h096, 0, 3, 0);
    @(negedge clk);
    cmp("R4 voted data", dataQ, 8'h96);
    cmp("R4 noise status", statusQ, 8'h24);
    clearAll();

    // R5 framing
    sendFrame(9'h00F, 0, -1, 1);
    @(negedge clk);
    cmp("R5 data", dataQ, 8'h0F);
    cmp("R5 framing status", statusQ, 8'h22);
    clearAll();

    // R13 false start
    waitTick();
    rxDrv = 0;
    holdTicks(4);
    rxDrv = 1;
    holdTicks(40);
    cmp("R13 no char", {7'b0, statusQ[5]}, 8'h00);
    sendFrame(9'h042, 0, -1, 0);
    @(negedge clk);
    cmp("R13 resumes hunting", dataQ, 8'h42);
    clearAll();

    // R11 interrupts
    regWrite(1, 8'h20);
    cmp("R11 irq idle", {7'b0, irq}, 8'h00);
    sendFrame(9'h011, 0, -1, 0);
    @(negedge clk);
    cmp("R11 irq on full", {7'b0, irq}, 8'h01);
    clearAll();
    cmp("R11 irq cleared", {7'b0, irq}, 8'h00);
    regWrite(1, 8'h10);
    holdTicks(170);
    cmp("R11 irq on idle", {7'b0, irq}, 8'h01);
    clearAll();
    cmp("R11 idle irq cleared", {7'b0, irq}, 8'h00);

    // R10 wakeup
    regWrite(1, 8'h32);
    sendFrame(9'h077, 0, -1, 0);
    @(negedge clk);
    cmp("R10 frame dropped", statusQ, 8'h00);
    cmp("R10 data kept", dataQ, 8'h11);
    cmp("R10 irq muted", {7'b0, irq}, 8'h00);
    holdTicks(170);
    cmp("R10 hw clears wakeup", ctrl2Q, 8'h30);
    cmp("R10 no idle flag", {7'b0, statusQ[4]}, 8'h00);
    sendFrame(9'h066, 0, -1, 0);
    @(negedge clk);
    cmp("R10 reception resumes", dataQ, 8'h66);
    cmp("R11 irq after wake", {7'b0, irq}, 8'h01);
    clearAll();

    // R12 break
    regWrite(1, 8'h01);
    holdTicks(10);
    cmp("R12 break low", {7'b0, txLine}, 8'h00);
    regWrite(1, 8'h00);
    @(negedge clk);
    cmp("R12 break released", {7'b0, txLine}, 8'h01);

    holdTicks(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule